// File: doc/BRIEF.md
# Segmented Polynomial Function Approximator

This block approximates a smooth function of one variable in fixed point. The argument's domain is cut into a power-of-two number of equal segments. Each segment has one row of a small on-chip coefficient table, holding an expansion point and the coefficients of a local polynomial. For each argument the block picks the row from a fixed group of argument bits. It subtracts the row's expansion point from the argument and evaluates the polynomial in the difference by Horner's scheme, using one multiply stage and one add stage for each order.

Arguments enter on a valid/ready stream and the block holds one evaluation at a time. `in_ready` is high only while no evaluation is in flight. A beat moves on a clock edge where `in_valid` and `in_ready` are both high, and `in_valid` on any other edge is ignored. The result leaves on a valid-only channel: `out_valid` is a single-cycle pulse and the output cannot apply back-pressure, so the consumer must take the result on the cycle it appears. `out_data` keeps its value until the next result. A separate write port loads the coefficient table. The polynomial order and the segment exponent are elaboration parameters.

Top module: `poly_seg_approx`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, `out_data` is 0, and every table word is 0, so an evaluation before any table write returns 0.
- R2: An argument is captured on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the edge after that capture until the result pulse, and it is 1 in the cycle of the pulse.
- R3: `out_valid` is high for exactly one cycle, starting 3 + 2·ORDER clock edges after the capturing edge (13 with the defaults ORDER = 5, SEG_BITS = 3).
- R4: The segment index is argument bits [ARG_FRAC-1 : ARG_FRAC-SEG_BITS], which are bits [27:25] with the defaults. The sign and integer bits do not affect the choice of segment.
- R5: A table row holds ORDER+2 words of COEF_W bits with COEF_FRAC fraction bits. Term 0 is the expansion point x0 and term k+1 is coefficient c_k. Each word is sign-extended and shifted left by ARG_FRAC-COEF_FRAC to take the argument's format.
- R6: The polynomial variable is z = x − x0, taken modulo 2^ARG_W.
- R7: The result equals acc after this loop: acc = c_n; then for k = n−1 down to 0, acc = low ARG_W bits of ((acc·z) >>> ARG_FRAC) + c_k. The product is full precision and signed, and the shift is arithmetic.
- R8: `out_data` changes only in a cycle in which `out_valid` is 1.
- R9: A table write with `tbl_we` = 1 stores `tbl_data` at (`tbl_seg`, `tbl_term`) on the clock edge. A write with `tbl_term` ≥ ORDER+2 changes nothing.
- R10: Arguments presented while an evaluation is in flight are ignored, and the result belongs to the argument that was captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Argument beat offered |
| in_ready | output | 1 | Block idle and able to take an argument |
| in_arg | input | ARG_W (32) | Argument, two's complement, ARG_FRAC fraction bits |
| tbl_we | input | 1 | Table write strobe |
| tbl_seg | input | SEG_BITS (3) | Row (segment) to write |
| tbl_term | input | clog2(ORDER+2) (3) | Word in the row: 0 = x0, k+1 = c_k |
| tbl_data | input | COEF_W (16) | Table word, two's complement, COEF_FRAC fraction bits |
| out_valid | output | 1 | One-cycle result pulse |
| out_data | output | ARG_W (32) | Result, same format as the argument |

## Verification
The assertions take for granted that the table is not written while an evaluation is in flight, because a write in that window would mix coefficients from before and after the write into one result. The stimulus writes the table only while `in_ready` is high and no argument is being offered, and it waits for the result pulse before the next group of writes. The assertions also take for granted that the consumer never needs to stall the output. The bench samples every cycle and never models a stall.

// File: rtl/spa_pkg.sv
package spa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEG  = 3'd1,
    ST_BASE = 3'd2,
    ST_CTR  = 3'd3,
    ST_MUL  = 3'd4,
    ST_ADD  = 3'd5
  } spa_state_e;

endpackage

// File: rtl/spa_coef_table.sv
module spa_coef_table #(
  parameter int SEGS   = 8,
  parameter int TERMS  = 7,
  parameter int COEF_W = 16,
  parameter int SEG_W  = 3,
  parameter int TERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic [TERM_W-1:0] wr_term,
  input  logic [COEF_W-1:0] wr_data,
  input  logic [SEG_W-1:0]  rd_seg,
  input  logic [TERM_W-1:0] rd_term,
  output logic [COEF_W-1:0] rd_base,
  output logic [COEF_W-1:0] rd_coef
);

  logic [COEF_W-1:0] mem [SEGS][TERMS];

  // One register row per segment; out-of-range terms are dropped.
  for (genvar s = 0; s < SEGS; s++) begin : g_row
    for (genvar t = 0; t < TERMS; t++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mem[s][t] <= '0;
        end else if (wr_en && (wr_seg == SEG_W'(s)) && (wr_term == TERM_W'(t))) begin
          mem[s][t] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    rd_base = mem[rd_seg][0];
    rd_coef = '0;
    for (int t = 0; t < TERMS; t++) begin
      if (rd_term == TERM_W'(t)) rd_coef = mem[rd_seg][t];
    end
  end

endmodule

// File: rtl/spa_ctrl.sv
module spa_ctrl
  import spa_pkg::*;
#(
  parameter int ORDER = 5,
  parameter int K_W   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  output logic           accept,
  output logic           last_step,
  output logic           out_valid,
  output spa_state_e     state,
  output logic [K_W-1:0] k_cnt
);

  localparam int LATENCY = 3 + 2 * ORDER;
  localparam int LAT_W   = $clog2(LATENCY + 2) + 1;

  spa_state_e     state_q;
  logic [K_W-1:0] k_q;
  logic           ov_q;

  assign state     = state_q;
  assign k_cnt     = k_q;
  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign last_step = (state_q == ST_ADD) && (k_q == K_W'(1));
  assign out_valid = ov_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      ov_q    <= 1'b0;
    end else begin
      ov_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (in_valid) state_q <= ST_SEG;
        ST_SEG:  state_q <= ST_BASE;
        ST_BASE: state_q <= ST_CTR;
        ST_CTR: begin
          k_q     <= K_W'(ORDER);
          state_q <= ST_MUL;
        end
        ST_MUL:  state_q <= ST_ADD;
        ST_ADD: begin
          k_q <= k_q - K_W'(1);
          if (k_q == K_W'(1)) begin
            ov_q    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_MUL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Edge counter kept beside the FSM so latency is checked independently.
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n)               lat_q <= '0;
    else if (accept)          lat_q <= LAT_W'(1);
    else if (ov_q)            lat_q <= '0;
    else if (lat_q != '0)     lat_q <= lat_q + LAT_W'(1);
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat_q == LAT_W'(LATENCY + 1)));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r2_ready_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  a_r7_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MUL) |-> ((k_q >= K_W'(1)) && (k_q <= K_W'(ORDER))));

endmodule

// File: rtl/spa_datapath.sv
module spa_datapath
  import spa_pkg::*;
#(
  parameter int ORDER     = 5,
  parameter int ARG_W     = 32,
  parameter int ARG_FRAC  = 28,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int SEG_W     = 3,
  parameter int TERM_W    = 3,
  parameter int K_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spa_state_e        state,
  input  logic [K_W-1:0]    k_cnt,
  input  logic              accept,
  input  logic              last_step,
  input  logic [ARG_W-1:0]  in_arg,
  input  logic [COEF_W-1:0] tbl_base,
  input  logic [COEF_W-1:0] tbl_coef,
  output logic [SEG_W-1:0]  rd_seg,
  output logic [TERM_W-1:0] rd_term,
  output logic [ARG_W-1:0]  result
);

  localparam int SCALE_SH = ARG_FRAC - COEF_FRAC;
  localparam int SEG_LSB  = ARG_FRAC - SEG_W;
  localparam int PROD_W   = ARG_W + ARG_FRAC;

  function automatic logic signed [ARG_W-1:0] widen(input logic [COEF_W-1:0] c);
    logic signed [ARG_W-1:0] t;
    t = {{(ARG_W - COEF_W){c[COEF_W-1]}}, c};
    return t <<< SCALE_SH;
  endfunction

  logic signed [ARG_W-1:0]  arg_q, x0_q, z_q, acc_q, res_q;
  logic        [SEG_W-1:0]  seg_q;
  logic signed [ARG_W-1:0]  prod_q;
  logic signed [ARG_W-1:0]  mul_a;
  logic signed [PROD_W-1:0] mul_full;
  logic signed [ARG_W-1:0]  acc_next;

  assign rd_seg  = seg_q;
  assign rd_term = (state == ST_ADD) ? TERM_W'(k_cnt) : TERM_W'(ORDER + 1);
  assign result  = res_q;

  // First step multiplies the top coefficient, later steps the accumulator.
  assign mul_a    = (k_cnt == K_W'(ORDER)) ? widen(tbl_coef) : acc_q;
  assign mul_full = PROD_W'(mul_a) * PROD_W'(z_q);
  assign acc_next = prod_q + widen(tbl_coef);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_q  <= '0;
      seg_q  <= '0;
      x0_q   <= '0;
      z_q    <= '0;
      prod_q <= '0;
      acc_q  <= '0;
      res_q  <= '0;
    end else begin
      if (accept) arg_q <= in_arg;
      unique case (state)
        ST_SEG:  seg_q  <= arg_q[SEG_LSB +: SEG_W];
        ST_BASE: x0_q   <= widen(tbl_base);
        ST_CTR:  z_q    <= arg_q - x0_q;
        ST_MUL:  prod_q <= mul_full[ARG_FRAC +: ARG_W];
        ST_ADD: begin
          acc_q <= acc_next;
          if (last_step) res_q <= acc_next;
        end
        default: ;
      endcase
    end
  end

  a_r10_arg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(arg_q));

  a_r4_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MUL || state == ST_ADD) |=> $stable(seg_q));

  a_r6_z_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADD) |=> $stable(z_q));

endmodule

// File: rtl/poly_seg_approx.sv
module poly_seg_approx
  import spa_pkg::*;
#(
  parameter int ORDER     = 5,
  parameter int SEG_BITS  = 3,
  parameter int ARG_W     = 32,
  parameter int ARG_FRAC  = 28,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  localparam int TERMS    = ORDER + 2,
  localparam int TERM_W   = $clog2(TERMS),
  localparam int SEGS     = 1 << SEG_BITS,
  localparam int K_W      = $clog2(ORDER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ARG_W-1:0]  in_arg,
  input  logic              tbl_we,
  input  logic [SEG_BITS-1:0] tbl_seg,
  input  logic [TERM_W-1:0] tbl_term,
  input  logic [COEF_W-1:0] tbl_data,
  output logic              out_valid,
  output logic [ARG_W-1:0]  out_data
);

  spa_state_e          state;
  logic [K_W-1:0]      k_cnt;
  logic                accept, last_step;
  logic [SEG_BITS-1:0] rd_seg;
  logic [TERM_W-1:0]   rd_term;
  logic [COEF_W-1:0]   rd_base, rd_coef;

  spa_ctrl #(.ORDER(ORDER), .K_W(K_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .last_step (last_step),
    .out_valid (out_valid),
    .state     (state),
    .k_cnt     (k_cnt)
  );

  spa_coef_table #(
    .SEGS(SEGS), .TERMS(TERMS), .COEF_W(COEF_W), .SEG_W(SEG_BITS), .TERM_W(TERM_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_seg  (tbl_seg),
    .wr_term (tbl_term),
    .wr_data (tbl_data),
    .rd_seg  (rd_seg),
    .rd_term (rd_term),
    .rd_base (rd_base),
    .rd_coef (rd_coef)
  );

  spa_datapath #(
    .ORDER(ORDER), .ARG_W(ARG_W), .ARG_FRAC(ARG_FRAC), .COEF_W(COEF_W),
    .COEF_FRAC(COEF_FRAC), .SEG_W(SEG_BITS), .TERM_W(TERM_W), .K_W(K_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .k_cnt     (k_cnt),
    .accept    (accept),
    .last_step (last_step),
    .in_arg    (in_arg),
    .tbl_base  (rd_base),
    .tbl_coef  (rd_coef),
    .rd_seg    (rd_seg),
    .rd_term   (rd_term),
    .result    (out_data)
  );

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> in_ready);

endmodule

// File: tb/sim_poly_seg_approx.sv
module sim_poly_seg_approx;

  localparam int ORDER = 5;
  localparam int TERMS = ORDER + 2;
  localparam int LAT   = 3 + 2 * ORDER;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_arg = '0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_seg = '0;
  logic [2:0]  tbl_term = '0;
  logic [15:0] tbl_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  poly_seg_approx u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_arg(in_arg), .tbl_we(tbl_we), .tbl_seg(tbl_seg), .tbl_term(tbl_term),
    .tbl_data(tbl_data), .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // Behavioural reference state.
  shortint mtab [8][TERMS];
  bit      m_live = 0;
  bit      m_busy = 0;
  bit      m_ov   = 0;
  int      m_cnt  = 0;
  int      m_arg  = 0;
  int      m_res  = 0;

  function automatic int eval_ref(int a);
    int seg, x0, z, acc;
    longint p;
    seg = (a >>> 25) & 7;
    x0  = int'(mtab[seg][0]) <<< 14;
    z   = a - x0;
    acc = int'(mtab[seg][ORDER + 1]) <<< 14;
    for (int k = ORDER - 1; k >= 0; k--) begin
      p   = longint'(acc) * longint'(z);
      p   = p >>> 28;
      acc = int'(p) + (int'(mtab[seg][k + 1]) <<< 14);
    end
    return acc;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_live = 1; m_busy = 0; m_ov = 0; m_cnt = 0; m_res = 0;
      for (int s = 0; s < 8; s++)
        for (int t = 0; t < TERMS; t++) mtab[s][t] = 0;
    end else begin
      m_ov = 0;
      if (tbl_we && tbl_term < TERMS) mtab[tbl_seg][tbl_term] = shortint'(tbl_data);
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_ov = 1; m_busy = 0; m_res = eval_ref(m_arg);
        end
      end else if (in_valid) begin
        m_busy = 1; m_cnt = LAT; m_arg = int'(in_arg);
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge.
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && m_live) begin
      check("R2", 32'(in_ready), 32'(!m_busy));
      check("R3", 32'(out_valid), 32'(m_ov));
      if (m_ov) check(cur_req, out_data, m_res);
      else      check("R8", out_data, m_res);
    end
    if (cyc > 60000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=60000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(int s, int t, int v);
    @(negedge clk);
    tbl_we = 1; tbl_seg = 3'(s); tbl_term = 3'(t); tbl_data = 16'(v);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic run(int a);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_arg = a;
    @(negedge clk);
    in_valid = 0;
    repeat (LAT + 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle flags and empty table give a zero result.
    cur_req = "R1";
    check("R1", 32'(in_ready), 32'd1);
    check("R1", 32'(out_valid), 32'd0);
    check("R1", out_data, 32'd0);
    run(32'h0123_4567);
    check("R1", out_data, 32'd0);

    // R5: rows of x0 at segment midpoints plus varied coefficients.
    for (int s = 0; s < 8; s++) begin
      wr(s, 0, s * 2048 + 1024);
      for (int k = 1; k < TERMS; k++) wr(s, k, ((s * 731 + k * 2917 + 123) % 16384) - 8192);
    end
    cur_req = "R7";
    for (int s = 0; s < 8; s++) begin
      run((s << 25));
      run((s << 25) | 32'h01FF_FFFF);
      run((s << 25) | 32'h0100_0000);
      run((s << 25) | 32'h00AB_CDEF);
    end
    // R6: arguments below x0 give negative z.
    cur_req = "R6";
    run(32'h0000_0010);
    run(32'h0A00_0001);
    // R4: sign and integer bits do not change the segment.
    cur_req = "R4";
    run(32'hF600_1234);
    run(32'h3C12_3456);
    run(32'h8FFF_FFFF);
    // R5: extreme words wrap identically in the model.
    cur_req = "R5";
    for (int k = 0; k < TERMS; k++) wr(3, k, (k % 2) ? 16'h7FFF : 16'h8000);
    run(32'h0600_0000);
    run(32'h07FF_FFFF);
    // R9: a write to term 7 is dropped.
    cur_req = "R9";
    wr(2, 7, 16'h1234);
    run(32'h0500_0000);
    wr(2, 6, 16'h0400);
    run(32'h0500_0000);
    // R10: in_valid held high with a changing argument every cycle.
    cur_req = "R10";
    @(negedge clk);
    for (int i = 0; i < 70; i++) begin
      in_valid = 1; in_arg = 32'h0111_1111 * i;
      @(negedge clk);
    end
    in_valid = 0;
    repeat (LAT + 3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule